// File: doc/BRIEF.md
# Four-Instruction Accumulator Processor

This block is a small 8-bit accumulator machine with its own 64-byte memory. The instruction set has four operations: load the accumulator from memory, add a memory byte into the accumulator, store the accumulator to memory, and an unconditional jump. Every instruction runs as a fixed series of register-transfer steps. The steps move values between a program counter, an instruction register, a memory address register, a memory buffer register and the accumulator. One add-only unit with a registered output does all the arithmetic. It advances the program counter during fetch and forms the sum for the add instruction.

Before execution starts, a test environment fills memory through a preload write port while `run` is low. Raising `run` makes the sequencer take one micro-step per clock. Lowering `run` freezes the machine exactly where it stands. The accumulator and program counter are visible at all times on debug outputs.

Top module: `acc_cpu`

## Requirements
- R1: An active-low reset, at any time, clears the program counter and accumulator to 0, and the next instruction fetched is the one at address 0.
- R2: An instruction byte carries the operation in bits 7..6 and a memory address in bits 5..0. The operation codes are 00 load, 01 add, 10 jump and 11 store.
- R3: A fetch takes three clock cycles with `run` high. The program counter becomes its old value plus one at the end of the third cycle.
- R4: A load places the addressed memory byte in the accumulator at the end of its sixth cycle, counted from the start of its fetch, and not earlier.
- R5: An add places the wrapped (modulo 256) sum of the accumulator and the addressed memory byte in the accumulator at the end of its seventh cycle, and not earlier. No overflow indication is produced.
- R6: A store writes the accumulator into the addressed memory byte at the end of its fifth cycle and leaves the accumulator unchanged.
- R7: A jump loads the program counter with its 6-bit address, with the upper two bits zero, at the end of its fourth cycle.
- R8: The program counter is 8 bits wide, but only its low 6 bits select memory. After the byte at address 63 runs, the counter reads 64 and the next fetch reads address 0.
- R9: While `run` is low, no register and no memory byte changes, apart from preload writes.
- R10: A preload write stores `pl_data` at `pl_addr` on a clock edge where `run` is low. When `run` is high the preload port has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | High: advance one micro-step per clock |
| pl_we | input | 1 | Preload write strobe |
| pl_addr | input | 6 | Preload byte address |
| pl_data | input | 8 | Preload byte value |
| dbg_ac | output | 8 | Current accumulator |
| dbg_pc | output | 8 | Current program counter |

## Verification
The preload port and a store instruction can both try to write the same memory byte on the same clock edge. The bench provokes this by holding the preload strobe high, aimed at the store's target address, for the whole run of a program. It judges the outcome by reading that byte back with a later load instruction. The accumulator must show the computed sum and not the preload value. A second overlap is the fetch cycle in which the memory read and the program counter increment share an edge. Exact-cycle checks of the counter and accumulator cover that case.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_ADD   = 2'b01,
    OP_JUMP  = 2'b10,
    OP_STORE = 2'b11
  } op_e;

  // One enable per register transfer of a micro-step
  typedef struct packed {
    logic mar_pc;
    logic mar_ir;
    logic mbr_mem;
    logic mbr_ac;
    logic alu_inc;
    logic alu_add;
    logic pc_alu;
    logic pc_ir;
    logic ir_mbr;
    logic ac_mbr;
    logic ac_alu;
    logic mem_wr;
  } ctl_t;

endpackage

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] q
);

  function automatic logic [W-1:0] sum_wrap(input logic [W-1:0] x,
                                            input logic [W-1:0] y,
                                            input logic c);
    return x + y + {{(W-1){1'b0}}, c};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= sum_wrap(a, b, cin);
  end

endmodule

// File: rtl/acc_mem.sv
module acc_mem #(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_cpu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] op,
  output ctl_t       ctl,
  output logic       in_exec
);

  logic [1:0] step;
  logic       last;
  ctl_t       raw;

  always_comb begin
    raw  = '0;
    last = 1'b0;
    if (!in_exec) begin
      unique case (step)
        2'd0: raw.mar_pc = 1'b1;
        2'd1: begin raw.mbr_mem = 1'b1; raw.alu_inc = 1'b1; end
        default: begin raw.pc_alu = 1'b1; raw.ir_mbr = 1'b1; last = 1'b1; end
      endcase
    end else begin
      unique case (op_e'(op))
        OP_LOAD: begin
          unique case (step)
            2'd0: raw.mar_ir = 1'b1;
            2'd1: raw.mbr_mem = 1'b1;
            default: begin raw.ac_mbr = 1'b1; last = 1'b1; end
          endcase
        end
        OP_ADD: begin
          unique case (step)
            2'd0: raw.mar_ir = 1'b1;
            2'd1: raw.mbr_mem = 1'b1;
            2'd2: raw.alu_add = 1'b1;
            default: begin raw.ac_alu = 1'b1; last = 1'b1; end
          endcase
        end
        OP_STORE: begin
          if (step == 2'd0) begin
            raw.mar_ir = 1'b1;
            raw.mbr_ac = 1'b1;
          end else begin
            raw.mem_wr = 1'b1;
            last = 1'b1;
          end
        end
        default: begin raw.pc_ir = 1'b1; last = 1'b1; end
      endcase
    end
    ctl = run ? raw : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step    <= '0;
      in_exec <= 1'b0;
    end else if (run) begin
      if (last) begin
        step    <= '0;
        in_exec <= ~in_exec;
      end else begin
        step <= step + 2'd1;
      end
    end
  end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = DATA_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              pl_we,
  input  logic [ADDR_W-1:0] pl_addr,
  input  logic [DATA_W-1:0] pl_data,
  output logic [DATA_W-1:0] dbg_ac,
  output logic [DATA_W-1:0] dbg_pc
);

  localparam int OP_W = DATA_W - ADDR_W;

  logic [DATA_W-1:0] pc, ac, ir, mbr;
  logic [ADDR_W-1:0] mar;
  logic [ADDR_W-1:0] ir_addr;
  logic [OP_W-1:0]   ir_op;
  logic [DATA_W-1:0] mem_q, alu_q, alu_a, alu_b;
  logic              alu_en;
  logic              in_exec;
  ctl_t              ctl;

  // named internal events, used by the bound checker
  logic fetch_done, jump_done, add_done, load_done, cpu_we, pl_ok;

  assign ir_addr    = ir[ADDR_W-1:0];
  assign ir_op      = ir[DATA_W-1 -: OP_W];
  assign fetch_done = ctl.pc_alu;
  assign jump_done  = ctl.pc_ir;
  assign add_done   = ctl.ac_alu;
  assign load_done  = ctl.ac_mbr;
  assign cpu_we     = ctl.mem_wr;
  assign pl_ok      = pl_we & ~run;

  acc_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .op      (ir_op),
    .ctl     (ctl),
    .in_exec (in_exec)
  );

  assign alu_en = ctl.alu_inc | ctl.alu_add;
  assign alu_a  = ctl.alu_inc ? pc : ac;
  assign alu_b  = ctl.alu_inc ? '0 : mbr;

  acc_alu #(.W(DATA_W)) u_alu (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (alu_en),
    .a     (alu_a),
    .b     (alu_b),
    .cin   (ctl.alu_inc),
    .q     (alu_q)
  );

  acc_mem #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
    .clk   (clk),
    .we    (cpu_we | pl_ok),
    .waddr (cpu_we ? mar : pl_addr),
    .wdata (cpu_we ? mbr : pl_data),
    .raddr (mar),
    .rdata (mem_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc  <= '0;
      ac  <= '0;
      ir  <= '0;
      mbr <= '0;
      mar <= '0;
    end else begin
      if (ctl.mar_pc)  mar <= pc[ADDR_W-1:0];
      if (ctl.mar_ir)  mar <= ir_addr;
      if (ctl.mbr_mem) mbr <= mem_q;
      if (ctl.mbr_ac)  mbr <= ac;
      if (ctl.pc_alu)  pc  <= alu_q;
      if (ctl.pc_ir)   pc  <= DATA_W'(ir_addr);
      if (ctl.ir_mbr)  ir  <= mbr;
      if (ctl.ac_mbr)  ac  <= mbr;
      if (ctl.ac_alu)  ac  <= alu_q;
    end
  end

  assign dbg_ac = ac;
  assign dbg_pc = pc;

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic [DATA_W-1:0] pc,
  input logic [DATA_W-1:0] ac,
  input logic [DATA_W-1:0] mbr,
  input logic [ADDR_W-1:0] ir_addr,
  input logic              in_exec,
  input logic              fetch_done,
  input logic              jump_done,
  input logic              add_done,
  input logic              load_done,
  input logic              cpu_we
);

  // R3
  pc_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |=> pc == DATA_W'($past(pc) + 1'b1));

  // R7
  jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jump_done |=> pc == DATA_W'($past(ir_addr)));

  // R5
  add_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    add_done |=> ac == DATA_W'($past(ac) + $past(mbr)));

  // R4
  load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> ac == $past(mbr));

  // R6
  store_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_we |-> (mbr == ac) && in_exec);

  // R9
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(pc) && $stable(ac) && $stable(in_exec));

endmodule

bind acc_cpu acc_cpu_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run),
  .pc         (pc),
  .ac         (ac),
  .mbr        (mbr),
  .ir_addr    (ir_addr),
  .in_exec    (in_exec),
  .fetch_done (fetch_done),
  .jump_done  (jump_done),
  .add_done   (add_done),
  .load_done  (load_done),
  .cpu_we     (cpu_we)
);

// File: tb/sim_acc_cpu.sv
`timescale 1ns/1ps
module sim_acc_cpu;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic       pl_we = 1'b0;
  logic [5:0] pl_addr = '0;
  logic [7:0] pl_data = '0;
  logic [7:0] dbg_ac, dbg_pc;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  acc_cpu u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .pl_we   (pl_we),
    .pl_addr (pl_addr),
    .pl_data (pl_data),
    .dbg_ac  (dbg_ac),
    .dbg_pc  (dbg_pc)
  );

  // operands a, b and expected wrapped sum
  localparam logic [23:0] VEC [0:5] = '{
    24'h05_07_0C, 24'hFF_01_00, 24'h80_80_00,
    24'hF0_20_10, 24'h7F_7F_FE, 24'h00_00_00
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    run = 1'b0;
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic poke(input logic [5:0] a, input logic [7:0] d);
    pl_we = 1'b1; pl_addr = a; pl_data = d;
    step(1);
    pl_we = 1'b0;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) poke(6'(i), 8'h00);
  endtask

  // 0: LOAD 32, 1: ADD 33, 2: STORE 34, 3: LOAD 34, 4: JUMP 4
  task automatic load_prog(input logic [7:0] a, input logic [7:0] b);
    clear_mem();
    poke(6'd0, 8'h20);
    poke(6'd1, 8'h61);
    poke(6'd2, 8'hE2);
    poke(6'd3, 8'h22);
    poke(6'd4, 8'h84);
    poke(6'd32, a);
    poke(6'd33, b);
  endtask

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    // reset state
    do_reset();
    check("R1 pc after reset", dbg_pc, 8'h00);
    check("R1 ac after reset", dbg_ac, 8'h00);

    // exact-cycle walk through the program
    load_prog(8'h11, 8'h22);
    run = 1'b1;
    step(3);
    check("R3 pc after fetch", dbg_pc, 8'h01);
    step(2);
    check("R4 ac not yet loaded", dbg_ac, 8'h00);
    step(1);
    check("R4 R10 R2 ac loaded on sixth cycle", dbg_ac, 8'h11);
    step(6);
    check("R5 ac before seventh cycle", dbg_ac, 8'h11);
    step(1);
    check("R5 ac sum on seventh cycle", dbg_ac, 8'h33);
    run = 1'b0;
    step(5);
    check("R9 pc held", dbg_pc, 8'h02);
    check("R9 ac held", dbg_ac, 8'h33);
    run = 1'b1;
    step(5);
    check("R6 ac kept by store", dbg_ac, 8'h33);
    check("R3 pc after store", dbg_pc, 8'h03);
    step(6);
    check("R6 stored byte read back", dbg_ac, 8'h33);
    step(3);
    check("R3 pc before jump", dbg_pc, 8'h05);
    step(1);
    check("R7 pc after jump", dbg_pc, 8'h04);

    // preload held during run, colliding with the store to 34
    do_reset();
    load_prog(8'h40, 8'h03);
    pl_we = 1'b1; pl_addr = 6'd34; pl_data = 8'h5A;
    run = 1'b1;
    step(30);
    pl_we = 1'b0;
    check("R10 preload ignored while running", dbg_ac, 8'h43);

    // program counter beyond the memory range
    do_reset();
    clear_mem();
    poke(6'd0, 8'hBF);
    poke(6'd63, 8'h0A);
    poke(6'd10, 8'h6C);
    run = 1'b1;
    step(4);
    check("R7 jump to 63", dbg_pc, 8'h3F);
    step(3);
    check("R8 pc counts to 64", dbg_pc, 8'h40);
    step(3);
    check("R4 load after wrap fetch", dbg_ac, 8'h6C);
    step(3);
    check("R8 pc counts to 65", dbg_pc, 8'h41);
    step(1);
    check("R8 fetch at 64 read address 0", dbg_pc, 8'h3F);

    // reset while running
    rst_n = 1'b0;
    step(1);
    check("R1 pc on mid-run reset", dbg_pc, 8'h00);
    check("R1 ac on mid-run reset", dbg_ac, 8'h00);
    rst_n = 1'b1;
    run = 1'b0;
    step(1);

    // vector table: wrapped sums through store and reload
    for (int v = 0; v < 6; v++) begin
      do_reset();
      load_prog(VEC[v][23:16], VEC[v][15:8]);
      run = 1'b1;
      step(40);
      run = 1'b0;
      check($sformatf("R5 R6 sum vector %0d", v), dbg_ac, VEC[v][7:0]);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule